// File: doc/BRIEF.md
# External Memory Strobe Sequencer

This block runs one external memory access at a time on behalf of an internal master. A request carries an address, a direction, a target chip-select space and, for writes, the data. The sequencer then drives the address, one active-low chip select, a read/write direction line and an active-low read or write strobe. When the access ends it returns the captured read data together with a one-tick completion pulse.

The block is clocked at twice the external bus rate, so one bus clock period is two ticks of `clk`. Delays are therefore counted in half-period steps. Configuration inputs set several delays: from address to chip select, from chip select to the write strobe and back, and from the end of the read strobe to the release of chip select. Each space has its own read hold code. Only one selectable space receives the write adjustment. A space with its recovery enable bit set ignores every adjustment and uses basic timing.

Basic timing asserts chip select and the strobe on the same tick. The strobe lasts one bus period, and chip select is released with it. Configuration is sampled on the tick a request is accepted.

Top module: `xbus_strobe_seq`

## Requirements
- R1: Out of reset and whenever `busy` is low, every `bus_cs_n` bit, `bus_rd_n`, `bus_wr_n` and `bus_rw` are 1, and `rsp_done` is 0.
- R2: A request is accepted only while `busy` is low. A `req_valid` pulse during a running access starts no further access, so `busy` stays low after that access completes.
- R3: On an adjusted access, chip select follows the start of the access by a delay set by `cfg_tac`: code 0 gives 0 ticks, 1 gives 2 ticks, 2 gives 4 ticks, and the reserved code 3 gives 0 ticks.
- R4: A write to the space named by `cfg_wr_space` has a setup delay from chip-select assertion to write-strobe assertion and the same hold delay from write-strobe release to chip-select release. Both are 2·c+1 ticks, where c is `cfg_wr_tim`.
- R5: A write to any other space uses basic timing. Chip select and `bus_wr_n` fall on the same tick and rise on the same tick, with no address delay.
- R6: A read of space s keeps chip select low for 2·c ticks after `bus_rd_n` rises, where c is `cfg_rd_hold[2s+1:2s]`. Each space has its own code.
- R7: A space whose `cfg_rec_en` bit is 1 uses basic timing for reads and writes, whatever the other configuration says.
- R8: Every strobe is low for exactly 2 ticks (one bus period), and read and write strobes are never low together.
- R9: Read data is sampled from `bus_din` on the tick edge where `bus_rd_n` rises. It is presented on `rsp_rdata` while `rsp_done` is high.
- R10: `rsp_done` is high for one tick: the first tick after chip select is released. `busy` is low on the tick after that.
- R11: During an access at most one chip select is low, and it is the requested space. `bus_addr` is stable while `busy` is high. `bus_rw` is 0 for writes and 1 for reads.
- R12: Configuration changes made after a request is accepted have no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; two ticks per bus period |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_space | input | SW | Target chip-select space |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| cfg_tac | input | 2 | Address-to-chip-select delay code |
| cfg_wr_tim | input | 2 | Write setup/hold code |
| cfg_wr_space | input | SW | Space that receives write adjustment |
| cfg_rd_hold | input | 2·NS | Read hold codes, two bits per space |
| cfg_rec_en | input | NS | Recovery enable per space (forces basic timing) |
| busy | output | 1 | Access in progress |
| rsp_done | output | 1 | One-tick completion pulse |
| rsp_rdata | output | DW | Captured read data |
| bus_addr | output | AW | External address |
| bus_cs_n | output | NS | Active-low chip selects |
| bus_rw | output | 1 | Direction: 1 read, 0 write |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_wdata | output | DW | Write data to the bus |
| bus_din | input | DW | Read data from the bus |

## Verification
The bench builds the block with its defaults: four spaces and 16-bit address and data. With four spaces, each of the four read hold codes can go to a different space in a single pass, and one space can be both the write-adjusted space and recovery-enabled at the same time. With these widths, every setup, hold and address delay fits inside the tick counter, including the longest write at 7+2+7 ticks behind a 4-tick address delay. The bench's bus model drives valid data only while the read strobe is low, which exposes any capture taken one tick late.

// File: rtl/xbs_pkg.sv
package xbs_pkg;

   localparam int TW = 4;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_ADDR   = 3'd1,
      ST_SETUP  = 3'd2,
      ST_STROBE = 3'd3,
      ST_HOLD   = 3'd4,
      ST_FIN    = 3'd5
   } xbs_state_e;

   typedef struct packed {
      logic [TW-1:0] pre;
      logic [TW-1:0] setup;
      logic [TW-1:0] hold;
   } xbs_timing_t;

   // Address delay in ticks; the reserved code behaves as zero.
   function automatic logic [TW-1:0] tac_ticks(input logic [1:0] code);
      if (code == 2'b11) return '0;
      return TW'({code, 1'b0});
   endfunction

   // Half-period write delay: 2*code+1 ticks.
   function automatic logic [TW-1:0] half_ticks(input logic [1:0] code);
      return TW'({code, 1'b1});
   endfunction

endpackage

// File: rtl/xbs_timing_decode.sv
module xbs_timing_decode
   import xbs_pkg::*;
#(
   parameter int NS = 4,
   localparam int SW = (NS > 1) ? $clog2(NS) : 1
) (
   input  logic            is_write,
   input  logic [SW-1:0]   space,
   input  logic [1:0]      cfg_tac,
   input  logic [1:0]      cfg_wr_tim,
   input  logic [SW-1:0]   cfg_wr_space,
   input  logic [2*NS-1:0] cfg_rd_hold,
   input  logic [NS-1:0]   cfg_rec_en,
   output xbs_timing_t     tim
);

   logic [TW-1:0] rd_hold_t [NS];

   for (genvar g = 0; g < NS; g++) begin : g_rd_hold
      assign rd_hold_t[g] = TW'({cfg_rd_hold[2*g+1 -: 2], 1'b0});
   end

   logic adjusted;

   always_comb begin
      if (cfg_rec_en[space])
         adjusted = 1'b0;
      else if (is_write)
         adjusted = (space == cfg_wr_space);
      else
         adjusted = 1'b1;

      tim = '0;
      if (adjusted) begin
         tim.pre = tac_ticks(cfg_tac);
         if (is_write) begin
            tim.setup = half_ticks(cfg_wr_tim);
            tim.hold  = half_ticks(cfg_wr_tim);
         end else begin
            tim.hold  = rd_hold_t[space];
         end
      end
   end

endmodule

// File: rtl/xbs_fsm.sv
module xbs_fsm
   import xbs_pkg::*;
#(
   parameter int STROBE_TICKS = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  xbs_timing_t tim_in,
   output xbs_state_e  state,
   output logic        strobe_end,
   output logic        done,
   output logic        busy
);

   localparam logic [TW-1:0] STROBE_LAST = TW'(STROBE_TICKS - 1);

   xbs_state_e    state_q, state_d;
   logic [TW-1:0] cnt_q, cnt_d;
   logic [TW-1:0] setup_q, hold_q;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      unique case (state_q)
         ST_IDLE: begin
            if (start) begin
               if (tim_in.pre != '0) begin
                  state_d = ST_ADDR;
                  cnt_d   = tim_in.pre - 1'b1;
               end else if (tim_in.setup != '0) begin
                  state_d = ST_SETUP;
                  cnt_d   = tim_in.setup - 1'b1;
               end else begin
                  state_d = ST_STROBE;
                  cnt_d   = STROBE_LAST;
               end
            end
         end
         ST_ADDR: begin
            if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
            else if (setup_q != '0) begin
               state_d = ST_SETUP;
               cnt_d   = setup_q - 1'b1;
            end else begin
               state_d = ST_STROBE;
               cnt_d   = STROBE_LAST;
            end
         end
         ST_SETUP: begin
            if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
            else begin
               state_d = ST_STROBE;
               cnt_d   = STROBE_LAST;
            end
         end
         ST_STROBE: begin
            if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
            else if (hold_q != '0) begin
               state_d = ST_HOLD;
               cnt_d   = hold_q - 1'b1;
            end else begin
               state_d = ST_FIN;
            end
         end
         ST_HOLD: begin
            if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
            else state_d = ST_FIN;
         end
         ST_FIN:  state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         setup_q <= '0;
         hold_q  <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         if (state_q == ST_IDLE && start) begin
            setup_q <= tim_in.setup;
            hold_q  <= tim_in.hold;
         end
      end
   end

   assign state      = state_q;
   assign strobe_end = (state_q == ST_STROBE) && (cnt_q == '0);
   assign done       = (state_q == ST_FIN);
   assign busy       = (state_q != ST_IDLE);

endmodule

// File: rtl/xbs_pins.sv
module xbs_pins
   import xbs_pkg::*;
#(
   parameter int NS = 4,
   parameter int AW = 16,
   parameter int DW = 16,
   localparam int SW = (NS > 1) ? $clog2(NS) : 1
) (
   input  xbs_state_e    state,
   input  logic          lat_write,
   input  logic [SW-1:0] lat_space,
   input  logic [AW-1:0] lat_addr,
   input  logic [DW-1:0] lat_wdata,
   output logic [AW-1:0] bus_addr,
   output logic [NS-1:0] bus_cs_n,
   output logic          bus_rw,
   output logic          bus_rd_n,
   output logic          bus_wr_n,
   output logic [DW-1:0] bus_wdata
);

   logic cs_on, dir_on, strobe_on;

   assign cs_on     = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
   assign dir_on    = cs_on || (state == ST_ADDR);
   assign strobe_on = (state == ST_STROBE);

   for (genvar g = 0; g < NS; g++) begin : g_cs
      assign bus_cs_n[g] = !(cs_on && (lat_space == SW'(g)));
   end

   assign bus_rw    = dir_on ? !lat_write : 1'b1;
   assign bus_rd_n  = !(strobe_on && !lat_write);
   assign bus_wr_n  = !(strobe_on && lat_write);
   assign bus_addr  = lat_addr;
   assign bus_wdata = lat_wdata;

endmodule

// File: rtl/xbus_strobe_seq.sv
module xbus_strobe_seq
   import xbs_pkg::*;
#(
   parameter int NS = 4,
   parameter int AW = 16,
   parameter int DW = 16,
   localparam int SW = (NS > 1) ? $clog2(NS) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic            req_write,
   input  logic [SW-1:0]   req_space,
   input  logic [AW-1:0]   req_addr,
   input  logic [DW-1:0]   req_wdata,
   input  logic [1:0]      cfg_tac,
   input  logic [1:0]      cfg_wr_tim,
   input  logic [SW-1:0]   cfg_wr_space,
   input  logic [2*NS-1:0] cfg_rd_hold,
   input  logic [NS-1:0]   cfg_rec_en,
   output logic            busy,
   output logic            rsp_done,
   output logic [DW-1:0]   rsp_rdata,
   output logic [AW-1:0]   bus_addr,
   output logic [NS-1:0]   bus_cs_n,
   output logic            bus_rw,
   output logic            bus_rd_n,
   output logic            bus_wr_n,
   output logic [DW-1:0]   bus_wdata,
   input  logic [DW-1:0]   bus_din
);

   if (NS < 2 || NS > 8) begin : g_bad_ns
      $error("xbus_strobe_seq: NS must lie in 2..8");
   end
   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("xbus_strobe_seq: AW and DW must be positive");
   end

   xbs_timing_t   tim_d;
   xbs_state_e    state;
   logic          strobe_end, fsm_busy, fsm_done, accept;
   logic          lat_write;
   logic [SW-1:0] lat_space;
   logic [AW-1:0] lat_addr;
   logic [DW-1:0] lat_wdata;

   assign accept = req_valid && !fsm_busy;

   xbs_timing_decode #(.NS(NS)) decode_i (
      .is_write     (req_write),
      .space        (req_space),
      .cfg_tac      (cfg_tac),
      .cfg_wr_tim   (cfg_wr_tim),
      .cfg_wr_space (cfg_wr_space),
      .cfg_rd_hold  (cfg_rd_hold),
      .cfg_rec_en   (cfg_rec_en),
      .tim          (tim_d)
   );

   xbs_fsm #(.STROBE_TICKS(2)) fsm_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (accept),
      .tim_in     (tim_d),
      .state      (state),
      .strobe_end (strobe_end),
      .done       (fsm_done),
      .busy       (fsm_busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_write <= 1'b0;
         lat_space <= '0;
         lat_addr  <= '0;
         lat_wdata <= '0;
         rsp_rdata <= '0;
      end else begin
         if (accept) begin
            lat_write <= req_write;
            lat_space <= req_space;
            lat_addr  <= req_addr;
            lat_wdata <= req_wdata;
         end
         if (strobe_end && !lat_write)
            rsp_rdata <= bus_din;
      end
   end

   xbs_pins #(.NS(NS), .AW(AW), .DW(DW)) pins_i (
      .state     (state),
      .lat_write (lat_write),
      .lat_space (lat_space),
      .lat_addr  (lat_addr),
      .lat_wdata (lat_wdata),
      .bus_addr  (bus_addr),
      .bus_cs_n  (bus_cs_n),
      .bus_rw    (bus_rw),
      .bus_rd_n  (bus_rd_n),
      .bus_wr_n  (bus_wr_n),
      .bus_wdata (bus_wdata)
   );

   assign busy     = fsm_busy;
   assign rsp_done = fsm_done;

endmodule

// File: rtl/xbs_checker.sv
module xbs_checker #(
   parameter int NS = 4,
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          rsp_done,
   input logic [AW-1:0] bus_addr,
   input logic [NS-1:0] bus_cs_n,
   input logic          bus_rw,
   input logic          bus_rd_n,
   input logic          bus_wr_n
);

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> ((&bus_cs_n) && bus_rd_n && bus_wr_n && bus_rw && !rsp_done));

   p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(!bus_rd_n && !bus_wr_n));

   p_rd_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_rd_n) |=> (!bus_rd_n ##1 bus_rd_n));

   p_wr_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_wr_n) |=> (!bus_wr_n ##1 bus_wr_n));

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> (!rsp_done && !busy));

   p_done_cs_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> (&bus_cs_n));

   p_one_cs_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~bus_cs_n) <= 1);

   p_strobe_in_cs_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_rd_n || !bus_wr_n) |-> !(&bus_cs_n));

   p_addr_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(bus_addr));

   p_write_dir_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr_n |-> !bus_rw);

endmodule

bind xbus_strobe_seq xbs_checker #(.NS(NS), .AW(AW)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .rsp_done (rsp_done),
   .bus_addr (bus_addr),
   .bus_cs_n (bus_cs_n),
   .bus_rw   (bus_rw),
   .bus_rd_n (bus_rd_n),
   .bus_wr_n (bus_wr_n)
);

// File: tb/xbus_strobe_seq_tb_top.sv
`timescale 1ns/1ps
module xbus_strobe_seq_tb_top;

   localparam int NS = 4;
   localparam int AW = 16;
   localparam int DW = 16;
   localparam int SW = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0, req_write = 1'b0;
   logic [SW-1:0]   req_space = '0;
   logic [AW-1:0]   req_addr = '0;
   logic [DW-1:0]   req_wdata = '0;
   logic [1:0]      cfg_tac = '0, cfg_wr_tim = '0;
   logic [SW-1:0]   cfg_wr_space = '0;
   logic [2*NS-1:0] cfg_rd_hold = '0;
   logic [NS-1:0]   cfg_rec_en = '0;
   logic            busy, rsp_done, bus_rw, bus_rd_n, bus_wr_n;
   logic [DW-1:0]   rsp_rdata, bus_wdata, bus_din;
   logic [AW-1:0]   bus_addr;
   logic [NS-1:0]   bus_cs_n;

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   // Bus model: valid data only while the read strobe is low.
   assign bus_din = !bus_rd_n ? (bus_addr ^ 16'h5A3C) : 16'hDEAD;

   xbus_strobe_seq #(.NS(NS), .AW(AW), .DW(DW)) dut_i (.*);

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Issue one access and measure its phases in ticks.
   task automatic do_cycle(input bit wr, input int sp, input logic [15:0] a,
                           input logic [15:0] wd, input int ep, input int es,
                           input int est, input int eh, input bit chg, input string tag);
      int pre = 0, setup = 0, strb = 0, hold = 0, bad_cs = 0, bad_dir = 0;
      bit seen_strobe = 0, got_done = 0;
      @(negedge clk);
      req_valid = 1; req_write = wr; req_space = SW'(sp); req_addr = a; req_wdata = wd;
      @(negedge clk);
      req_valid = 0;
      if (chg) begin
         cfg_tac = 2'd2; cfg_wr_tim = 2'd3; cfg_rd_hold = '1; cfg_rec_en = '0;
      end
      for (int i = 0; i < 64 && !got_done; i++) begin
         if (rsp_done) begin
            got_done = 1;
            if (!wr) check(rsp_rdata == (a ^ 16'h5A3C), {tag, " R9 rdata"}, rsp_rdata, a ^ 16'h5A3C);
            check(&bus_cs_n, {tag, " R10 cs released at done"}, bus_cs_n, 15);
         end else begin
            if (!(&bus_cs_n) && bus_cs_n != ~(NS'(1) << sp)) bad_cs++;
            if (busy && bus_rw != !wr) bad_dir++;
            if (&bus_cs_n) begin
               if (!bus_rd_n || !bus_wr_n) bad_cs++;
               pre++;
            end else if (!bus_rd_n || !bus_wr_n) begin
               if ((wr && bus_wr_n) || (!wr && bus_rd_n)) bad_dir++;
               if (wr && bus_wdata != wd) bad_dir++;
               strb++; seen_strobe = 1;
            end else if (!seen_strobe) setup++;
            else hold++;
            @(negedge clk);
         end
      end
      check(got_done, {tag, " R10 done seen"}, got_done, 1);
      check(pre == ep, {tag, " R3 address delay"}, pre, ep);
      check(setup == es, {tag, " R4 setup"}, setup, es);
      check(strb == est, {tag, " R8 strobe width"}, strb, est);
      check(hold == eh, {tag, " R6 hold"}, hold, eh);
      check(bad_cs == 0 && bad_dir == 0, {tag, " R11 cs/dir"}, bad_cs + bad_dir, 0);
      @(negedge clk);
      check(!busy && !rsp_done, {tag, " R10 single done"}, busy, 0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(&bus_cs_n && bus_rd_n && bus_wr_n && bus_rw && !rsp_done && !busy,
            "R1 reset idle", {bus_cs_n, bus_rd_n, bus_wr_n, bus_rw}, 127);
   endtask

   task automatic t_read_hold();
      cfg_tac = 2'd1; cfg_rec_en = '0;
      cfg_rd_hold = {2'd3, 2'd2, 2'd1, 2'd0};
      for (int s = 0; s < NS; s++)
         do_cycle(0, s, 16'h1200 + 16'(s), 0, 2, 0, 2, 2*s, 0, $sformatf("R6 read sp%0d", s));
   endtask

   task automatic t_tac_codes();
      cfg_rd_hold = '0;
      cfg_tac = 2'd0; do_cycle(0, 1, 16'h0040, 0, 0, 0, 2, 0, 0, "R3 tac0");
      cfg_tac = 2'd2; do_cycle(0, 1, 16'h0041, 0, 4, 0, 2, 0, 0, "R3 tac2");
      cfg_tac = 2'd3; do_cycle(0, 1, 16'h0042, 0, 0, 0, 2, 0, 0, "R3 tac3 reserved");
   endtask

   task automatic t_write_selected();
      cfg_wr_space = 2'd2; cfg_tac = 2'd2;
      cfg_wr_tim = 2'd0; do_cycle(1, 2, 16'h2000, 16'hBEEF, 4, 1, 2, 1, 0, "R4 write c0");
      cfg_wr_tim = 2'd3; do_cycle(1, 2, 16'h2002, 16'hCAFE, 4, 7, 2, 7, 0, "R4 write c3");
   endtask

   task automatic t_write_other();
      cfg_wr_space = 2'd2; cfg_wr_tim = 2'd3; cfg_tac = 2'd2;
      do_cycle(1, 1, 16'h3000, 16'h1234, 0, 0, 2, 0, 0, "R5 write other");
      do_cycle(1, 0, 16'h3004, 16'h4321, 0, 0, 2, 0, 0, "R5 write sp0");
   endtask

   task automatic t_recovery();
      cfg_rec_en = 4'b1000; cfg_wr_space = 2'd3; cfg_wr_tim = 2'd2;
      cfg_tac = 2'd2; cfg_rd_hold = '1;
      do_cycle(0, 3, 16'h4000, 0, 0, 0, 2, 0, 0, "R7 recovery read");
      do_cycle(1, 3, 16'h4002, 16'h7777, 0, 0, 2, 0, 0, "R7 recovery write");
      do_cycle(0, 2, 16'h4004, 0, 4, 0, 2, 6, 0, "R7 neighbour read adjusted");
      cfg_rec_en = '0;
   endtask

   task automatic t_cfg_change();
      cfg_tac = 2'd0; cfg_rd_hold = '0; cfg_wr_tim = 2'd0; cfg_wr_space = 2'd0;
      do_cycle(0, 0, 16'h5000, 0, 0, 0, 2, 0, 1, "R12 read cfg change");
      cfg_tac = 2'd0; cfg_rd_hold = '0; cfg_wr_tim = 2'd0;
      do_cycle(1, 0, 16'h5002, 16'h0F0F, 0, 1, 2, 1, 1, "R12 write cfg change");
   endtask

   task automatic t_busy_ignore();
      bit got_done = 0;
      int starts = 0;
      cfg_tac = 2'd0; cfg_wr_space = 2'd1; cfg_wr_tim = 2'd3; cfg_rec_en = '0;
      @(negedge clk);
      req_valid = 1; req_write = 1; req_space = 2'd1; req_addr = 16'h6000; req_wdata = 16'h55AA;
      @(negedge clk);
      req_valid = 0;
      repeat (3) @(negedge clk);
      req_valid = 1; req_write = 0; req_space = 2'd3; req_addr = 16'h6100;
      @(negedge clk);
      req_valid = 0;
      for (int i = 0; i < 64 && !got_done; i++) begin
         if (!bus_cs_n[3]) starts++;
         if (rsp_done) got_done = 1; else @(negedge clk);
      end
      check(got_done && starts == 0, "R2 request while busy not taken", starts, 0);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check(!busy && (&bus_cs_n), "R2 idle after done", busy, 0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_reset();
      t_read_hold();
      t_tac_codes();
      t_write_selected();
      t_write_other();
      t_recovery();
      t_cfg_change();
      t_busy_ignore();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule